// File: doc/BRIEF.md
# Held-Choice Direction Selector

This block turns a vector of direction buttons into a steering decision for a grid game that advances in discrete ticks. The raw button lines pass through a two-stage synchroniser. Only the four lowest lines are looked at. On each tick a fixed-priority encoder resolves whatever is pressed into a single direction, and a register stores that direction.

When a tick arrives with no direction pressed, the stored direction is reused. The game therefore keeps moving the way it last went. After reset the stored direction is a fixed default, which is right.

The result is presented in two forms: a 2-bit direction code and a one-hot handler-select vector. A one-cycle valid strobe follows every tick, including ticks where the held value is reused. Between ticks the outputs do not move.

Top module: `dir_select`

## Requirements
- R1: After reset, `dir_code` is 01 (right), `dir_onehot` is 0010 and `dir_valid` is 0.
- R2: Input bits at position 4 and above have no effect. A vector whose low four bits are zero behaves as no press, whatever its upper bits hold.
- R3: Button bit 0 is up (code 00), bit 1 is right (code 01), bit 2 is down (code 10) and bit 3 is left (code 11). When several bits are set, the lowest set bit wins.
- R4: A tick that sees none of the low four bits set leaves the stored direction unchanged.
- R5: The stored direction changes only in the cycle after a tick. Between ticks the outputs stay stable, even while the buttons change.
- R6: `dir_valid` is high for exactly one cycle after each cycle in which `tick` is high, and is low otherwise. This includes ticks that reuse the held direction.
- R7: `dir_onehot` has exactly one bit set, at the position given by `dir_code`.
- R8: A button value must be present at two rising edges before the tick edge to be seen. A value that changes in the same cycle as the tick is not yet seen by that tick, which resolves from the previous synchronised value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| buttons | input | IN_W (8) | Raw button lines; low four are up, right, down, left |
| tick | input | 1 | One-cycle game-tick enable |
| dir_code | output | 2 | Held direction code |
| dir_onehot | output | 4 | One-hot handler select for the held direction |
| dir_valid | output | 1 | Strobe one cycle after each tick |

## Verification
Two functions can fall in the same cycle: a tick, and a change on the button lines that has not yet passed the synchroniser. The bench provokes this by changing the buttons and raising the tick in the same cycle. The strobed direction must then be the decision on the old synchronised value, and a later tick must show the new one. The second overlap is a tick with nothing pressed, where the hold path and the valid strobe act together. This is judged by the strobe appearing while the code keeps its previous value.

// File: rtl/dirsel_pkg.sv
package dirsel_pkg;
    localparam int DIRS = 4;
    localparam int CODE_W = $clog2(DIRS);

    typedef enum logic [CODE_W-1:0] {
        DIR_UP    = 2'd0,
        DIR_RIGHT = 2'd1,
        DIR_DOWN  = 2'd2,
        DIR_LEFT  = 2'd3
    } dir_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = raw;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign synced = s_q.stable;

    // R8: the output copies the first stage one cycle later
    p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> synced == $past(s_q.meta));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N  = 4,
    parameter int CW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [CW-1:0] code
);
    always_comb begin
        found = 1'b0;
        code  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                code  = CW'(i);
            end
        end
    end

    always_comb begin
        // R4: an empty vector must report nothing found
        p_empty_none_r4: assert (vec != '0 || !found);
        // R3: the chosen bit is set and no lower bit is set
        if (found) begin
            p_pick_set_r3: assert (vec[code]);
            p_lowest_r3: assert ((vec & ((N'(1) << code) - N'(1))) == '0);
        end
    end
endmodule

// File: rtl/choice_hold.sv
module choice_hold #(
    parameter int CW = 2,
    parameter logic [CW-1:0] RESET_DIR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          found,
    input  logic [CW-1:0] pick,
    output logic [CW-1:0] dir_q,
    output logic          valid_q
);
    typedef struct packed {
        logic [CW-1:0] dir;
        logic          valid;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        h_d.valid = tick;
        if (tick && found) h_d.dir = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{dir: RESET_DIR, valid: 1'b0};
        else        h_q <= h_d;
    end

    assign dir_q   = h_q.dir;
    assign valid_q = h_q.valid;

    // R5: no tick, no movement
    p_stable_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(dir_q));
    // R4: a tick with nothing pressed keeps the direction
    p_hold_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !found) |-> $stable(dir_q));
    // R6: strobe follows every tick
    p_strobe_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) |-> valid_q);
    // R6: no strobe without a tick
    p_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> !valid_q);
endmodule

// File: rtl/dir_select.sv
module dir_select #(
    parameter int IN_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IN_W-1:0]             buttons,
    input  logic                        tick,
    output logic [dirsel_pkg::CODE_W-1:0] dir_code,
    output logic [dirsel_pkg::DIRS-1:0] dir_onehot,
    output logic                        dir_valid
);
    import dirsel_pkg::*;

    logic [DIRS-1:0]   btn_low;
    logic [DIRS-1:0]   btn_sync_q;
    logic              any_press;
    logic [CODE_W-1:0] pick_code;

    assign btn_low = buttons[DIRS-1:0];

    generate
        if (IN_W > DIRS) begin : g_upper
            logic [IN_W-DIRS-1:0] upper_unused;
            assign upper_unused = buttons[IN_W-1:DIRS];
        end
    endgenerate

    btn_sync #(.W(DIRS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (btn_low),
        .synced(btn_sync_q)
    );

    prio_pick #(.N(DIRS), .CW(CODE_W)) u_pick (
        .vec  (btn_sync_q),
        .found(any_press),
        .code (pick_code)
    );

    choice_hold #(.CW(CODE_W), .RESET_DIR(DIR_RIGHT)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .found  (any_press),
        .pick   (pick_code),
        .dir_q  (dir_code),
        .valid_q(dir_valid)
    );

    generate
        for (genvar k = 0; k < DIRS; k++) begin : g_onehot
            assign dir_onehot[k] = (dir_code == CODE_W'(k));
        end
    endgenerate

    // R7: exactly one handler selected
    p_onehot_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dir_onehot) == 1);
endmodule

// File: tb/test_dir_select.sv
module test_dir_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] buttons = '0;
    logic       tick = 1'b0;
    logic [1:0] dir_code;
    logic [3:0] dir_onehot;
    logic       dir_valid;

    int checks = 0;
    int failures = 0;
    logic [1:0] exp_q[$];
    logic [1:0] model_dir = 2'd1;
    logic [7:0] model_btn = '0;
    bit done = 0;

    always #4 clk = ~clk;

    dir_select #(.IN_W(8)) i_dir_select (
        .clk(clk), .rst_n(rst_n), .buttons(buttons), .tick(tick),
        .dir_code(dir_code), .dir_onehot(dir_onehot), .dir_valid(dir_valid)
    );

    function automatic logic [1:0] resolve(input logic [7:0] b, input logic [1:0] held);
        if (b[0])      return 2'd0;
        else if (b[1]) return 2'd1;
        else if (b[2]) return 2'd2;
        else if (b[3]) return 2'd3;
        else           return held;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expectation per strobe
    always @(negedge clk) begin
        if (rst_n && !done && dir_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected strobe", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check(dir_code == e, "R3/R4 code", dir_code, e);
                check(dir_onehot == (4'b1 << e), "R7 onehot", dir_onehot, 4'b1 << e);
            end
        end
    end

    task automatic do_tick(input logic [7:0] b);
        @(negedge clk);
        buttons = b;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        model_dir = resolve(b, model_dir);
        model_btn = b;
        exp_q.push_back(model_dir);
        @(negedge clk);
        tick = 1'b0;
    endtask

    // R8: buttons change in the tick cycle itself
    task automatic tick_same_cycle(input logic [7:0] b);
        @(negedge clk);
        buttons = b;
        tick = 1'b1;
        model_dir = resolve(model_btn, model_dir);
        exp_q.push_back(model_dir);
        @(negedge clk);
        tick = 1'b0;
        model_btn = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dir_code == 2'd1, "R1 code", dir_code, 1);
        check(dir_onehot == 4'b0010, "R1 onehot", dir_onehot, 4'b0010);
        check(dir_valid == 1'b0, "R1 valid", dir_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dir_valid == 1'b0, "R6 idle", dir_valid, 0);

        do_tick(8'h00);              // R4 hold default, R6 strobe on hold
        do_tick(8'h01);              // R3 up
        do_tick(8'h02);              // R3 right
        do_tick(8'h04);              // R3 down
        do_tick(8'h08);              // R3 left
        do_tick(8'h00);              // R4 hold left
        do_tick(8'h03);              // R3 up wins
        do_tick(8'h06);              // R3 right wins
        do_tick(8'h0C);              // R3 down wins
        do_tick(8'h0F);              // R3 up wins
        do_tick(8'h0A);              // R3 right wins
        do_tick(8'h08);
        do_tick(8'hF0);              // R2 upper only: hold left
        do_tick(8'hF4);              // R2 upper ignored: down
        do_tick(8'h80);              // R2 hold down

        // R5: buttons change without a tick
        @(negedge clk);
        buttons = 8'h01;
        repeat (6) @(negedge clk);
        check(dir_code == model_dir, "R5 stable", dir_code, model_dir);
        buttons = 8'h08;
        repeat (6) @(negedge clk);
        check(dir_code == model_dir, "R5 stable", dir_code, model_dir);
        check(dir_valid == 1'b0, "R6 no strobe", dir_valid, 0);
        model_btn = 8'h08;

        // R8: same-cycle change uses the old synchronised value (left)
        do_tick(8'h08);
        tick_same_cycle(8'h01);
        do_tick(8'h01);              // now up is seen
        tick_same_cycle(8'h00);      // old value up still seen
        do_tick(8'h00);              // hold up

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all strobes seen", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule